// File: doc/BRIEF.md
# Sleep and Wake Sequencer

This block decides when a small 8-bit processor core may stop its clocks and how it comes back. The core arms sleep with a sleep-enable bit and a 3-bit mode code. It then issues a one-cycle strobe when it executes its sleep instruction. The block latches the mode and stalls the core. It switches off the clock domains that the chosen mode does not need: CPU, I/O, ADC, asynchronous timer and main oscillator. It then waits for an interrupt request that the mode accepts as a wake source.

On a wake, the block first lets the main oscillator settle. This start-up wait depends on the mode:
- A long, parameterized wait when the oscillator was stopped.
- A short wait in the mode that keeps the oscillator running.
- No wait in the light modes.

After the start-up wait, the core stays stalled for exactly four more cycles. The block then raises a one-cycle pulse telling the core to take its pending interrupt. After that the core resumes behind the sleep instruction, with its registers and memory intact.

A reset request at any time sends the block straight back to run with every clock on. That request alone produces a core reset pulse. A wake never does.

States: `ST_RUN` (normal execution), `ST_SLEEP` (clocks gated per mode), `ST_START` (oscillator start-up count), `ST_HALT` (four-cycle post-wake stall), `ST_SERVE` (one-cycle interrupt hand-off).

Transitions:

| From | To | Condition |
|---|---|---|
| `ST_RUN` | `ST_SLEEP` | strobe while sleep-enable is 1 |
| `ST_SLEEP` | `ST_START` | qualified wake in Power-down, Power-save or Standby |
| `ST_SLEEP` | `ST_HALT` | qualified wake in Idle or ADC Noise Reduction |
| `ST_START` | `ST_HALT` | count expired |
| `ST_HALT` | `ST_SERVE` | after four cycles |
| `ST_SERVE` | `ST_RUN` | unconditionally |
| any state | `ST_RUN` | reset request |

Top module: `sleep_sequencer`

## Requirements
- R1: A `sleep_strobe` in run with `sleep_en`=1 raises `cpu_stall` on the next cycle; a strobe with `sleep_en`=0 is ignored and `cpu_stall` stays 0.
- R2: `mode_sel` is latched at the accepted strobe and decoded as:
  - 000 Idle
  - 001 ADC Noise Reduction
  - 010 Power-down
  - 011 Power-save
  - 110 Standby
  - 100, 101 and 111 behave as Idle.
- R3: While asleep, the enables {cpu, io, adc, async, osc} are:
  - Idle 01111
  - ADC Noise Reduction 00111
  - Power-down 00000
  - Power-save 00010
  - Standby 00001
- R4: Wake sources accepted per mode:
  - `pin_irq` and `wdt_irq` wake in every mode.
  - `adc_irq` wakes in Idle and ADC Noise Reduction.
  - `tmr_irq` wakes in Idle, ADC Noise Reduction and Power-save.
  - `io_irq` wakes in Idle only.
  - Any other request leaves the block asleep with its clock enables unchanged.
- R5: `int0_req` wakes from Idle and ADC Noise Reduction in either sense. In Power-down, Power-save and Standby it wakes only with `int0_level`=1; with `int0_level`=0 it is ignored.
- R6: After a wake, the start-up wait lasts:
  - `LONG_CYC` cycles in Power-down and Power-save
  - `SHORT_CYC` cycles in Standby
  - 0 cycles in Idle and ADC Noise Reduction
  
  `osc_en` is 1 throughout the wait.
- R7: The start-up wait is followed by exactly 4 stall cycles with all clocks on, and then `irq_take` is 1 for exactly one cycle with `cpu_stall`=0. From the edge that sees the wake, the stall lasts start-up + 4 cycles.
- R8: A `rst_req` in any state returns the block to run on the next cycle: `cpu_stall`=0, all clocks on, `irq_take`=0.
- R9: `core_rst` is 1 exactly in the cycle after a cycle with `rst_req`=1 and is never raised by a wake.
- R10: In run, `cpu_stall`=0 and all five clock enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| rst_req | input | 1 | Synchronous system reset request (pin, watchdog, brown-out) |
| sleep_en | input | 1 | Sleep arm bit from the core |
| mode_sel | input | 3 | Sleep mode code |
| sleep_strobe | input | 1 | One-cycle pulse when the sleep instruction executes |
| int0_req | input | 1 | External interrupt 0 request, already enabled |
| int0_level | input | 1 | 1 when external interrupt 0 is configured as level sensed |
| pin_irq | input | 1 | Other enabled external or pin-change request |
| wdt_irq | input | 1 | Enabled watchdog interrupt request |
| adc_irq | input | 1 | Enabled ADC conversion-complete request |
| io_irq | input | 1 | Enabled request from synchronous I/O peripherals |
| tmr_irq | input | 1 | Enabled request from the asynchronous timer |
| cpu_stall | output | 1 | Core must hold |
| irq_take | output | 1 | One-cycle pulse: core may take its pending interrupt |
| core_rst | output | 1 | Core restart from the reset vector |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_adc_en | output | 1 | ADC clock enable |
| clk_async_en | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |

## Verification
The bench sweeps all eight mode codes against seven wake patterns, each applied on its own:
- edge-sensed INT0 and level-sensed INT0
- pin change
- watchdog
- ADC
- synchronous I/O
- asynchronous timer

The pin-change, watchdog and other patterns fill the qualification table per mode, which separates the five real modes. The two INT0 patterns separate the light modes from the deep ones. The reserved codes show that they collapse to Idle. Each wake measures the stall length, which tells the long, short and zero start-up paths apart. Each rejected request is followed by a pin-change wake, so that a stuck-asleep design is also caught. Separate runs cover a strobe while sleep is disarmed and reset requests during sleep and during start-up.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

    typedef enum logic [2:0] {
        MD_IDLE  = 3'b000,
        MD_ADCNR = 3'b001,
        MD_PDOWN = 3'b010,
        MD_PSAVE = 3'b011,
        MD_STBY  = 3'b110
    } mode_e;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_START = 3'd2,
        ST_HALT  = 3'd3,
        ST_SERVE = 3'd4
    } state_e;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic asyn;
        logic osc;
    } clk_gate_t;

    localparam int unsigned HALT_CYCLES = 4;

endpackage

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
    import sleep_pkg::*;
(
    input  logic [2:0] code,
    output mode_e      mode,
    output clk_gate_t  gate,
    output logic       need_start,
    output logic       long_start
);

    always_comb begin
        unique case (code)
            3'b001:  mode = MD_ADCNR;
            3'b010:  mode = MD_PDOWN;
            3'b011:  mode = MD_PSAVE;
            3'b110:  mode = MD_STBY;
            default: mode = MD_IDLE;
        endcase
    end

    always_comb begin
        unique case (mode)
            MD_IDLE:  gate = clk_gate_t'(5'b01111);
            MD_ADCNR: gate = clk_gate_t'(5'b00111);
            MD_PDOWN: gate = clk_gate_t'(5'b00000);
            MD_PSAVE: gate = clk_gate_t'(5'b00010);
            MD_STBY:  gate = clk_gate_t'(5'b00001);
            default:  gate = clk_gate_t'(5'b01111);
        endcase
    end

    assign need_start = (mode == MD_PDOWN) || (mode == MD_PSAVE) || (mode == MD_STBY);
    assign long_start = (mode == MD_PDOWN) || (mode == MD_PSAVE);

endmodule

// File: rtl/sleep_wake_qual.sv
module sleep_wake_qual
    import sleep_pkg::*;
(
    input  mode_e mode,
    input  logic  int0_req,
    input  logic  int0_level,
    input  logic  pin_irq,
    input  logic  wdt_irq,
    input  logic  adc_irq,
    input  logic  io_irq,
    input  logic  tmr_irq,
    output logic  wake
);

    logic deep;
    logic int0_ok;
    logic always_ok;

    // deep modes accept external interrupt 0 only when level sensed
    assign deep      = (mode == MD_PDOWN) || (mode == MD_PSAVE) || (mode == MD_STBY);
    assign int0_ok   = int0_req && (int0_level || !deep);
    assign always_ok = int0_ok || pin_irq || wdt_irq;

    always_comb begin
        unique case (mode)
            MD_IDLE:  wake = always_ok || adc_irq || io_irq || tmr_irq;
            MD_ADCNR: wake = always_ok || adc_irq || tmr_irq;
            MD_PSAVE: wake = always_ok || tmr_irq;
            MD_PDOWN: wake = always_ok;
            MD_STBY:  wake = always_ok;
            default:  wake = 1'b0;
        endcase
    end

endmodule

// File: rtl/sleep_delay_cnt.sv
module sleep_delay_cnt #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);

endmodule

// File: rtl/sleep_sequencer.sv
module sleep_sequencer
    import sleep_pkg::*;
#(
    parameter int unsigned LONG_CYC  = 16384,
    parameter int unsigned SHORT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       sleep_en,
    input  logic [2:0] mode_sel,
    input  logic       sleep_strobe,
    input  logic       int0_req,
    input  logic       int0_level,
    input  logic       pin_irq,
    input  logic       wdt_irq,
    input  logic       adc_irq,
    input  logic       io_irq,
    input  logic       tmr_irq,
    output logic       cpu_stall,
    output logic       irq_take,
    output logic       core_rst,
    output logic       clk_cpu_en,
    output logic       clk_io_en,
    output logic       clk_adc_en,
    output logic       clk_async_en,
    output logic       osc_en
);

    localparam int unsigned START_MAX = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned CNT_MAX   = (START_MAX > HALT_CYCLES) ? START_MAX : HALT_CYCLES;
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] HALT_V  = CNT_W'(HALT_CYCLES);
    localparam clk_gate_t ALL_ON = clk_gate_t'(5'b11111);

    state_e           st_q, st_d;
    logic [2:0]       code_q;
    logic             core_rst_q;
    logic             accept;
    mode_e            mode_w;
    clk_gate_t        sleep_gate;
    clk_gate_t        gate_o;
    logic             need_start;
    logic             long_start;
    logic             wake;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_last;
    logic [CNT_W-1:0] cnt_val;

    assign accept = (st_q == ST_RUN) && sleep_strobe && sleep_en && !rst_req;

    sleep_mode_decode u_dec (
        .code       (code_q),
        .mode       (mode_w),
        .gate       (sleep_gate),
        .need_start (need_start),
        .long_start (long_start)
    );

    sleep_wake_qual u_wake (
        .mode       (mode_w),
        .int0_req   (int0_req),
        .int0_level (int0_level),
        .pin_irq    (pin_irq),
        .wdt_irq    (wdt_irq),
        .adc_irq    (adc_irq),
        .io_irq     (io_irq),
        .tmr_irq    (tmr_irq),
        .wake       (wake)
    );

    sleep_delay_cnt #(.WIDTH(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    // state register, mode latch and reset pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_RUN;
            code_q     <= 3'b000;
            core_rst_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            core_rst_q <= rst_req;
            if (accept) begin
                code_q <= mode_sel;
            end
        end
    end

    // next state and counter control
    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_val  = HALT_V;
        if (rst_req) begin
            st_d = ST_RUN;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (accept) st_d = ST_SLEEP;
                end
                ST_SLEEP: begin
                    if (wake) begin
                        cnt_load = 1'b1;
                        if (need_start) begin
                            st_d    = ST_START;
                            cnt_val = long_start ? LONG_V : SHORT_V;
                        end else begin
                            st_d    = ST_HALT;
                            cnt_val = HALT_V;
                        end
                    end
                end
                ST_START: begin
                    if (cnt_last) begin
                        st_d     = ST_HALT;
                        cnt_load = 1'b1;
                        cnt_val  = HALT_V;
                    end
                end
                ST_HALT: begin
                    if (cnt_last) st_d = ST_SERVE;
                end
                ST_SERVE: begin
                    st_d = ST_RUN;
                end
                default: begin
                    st_d = ST_RUN;
                end
            endcase
        end
    end

    assign cnt_dec = !cnt_load && ((st_q == ST_START) || (st_q == ST_HALT));

    // outputs
    always_comb begin
        gate_o    = ALL_ON;
        cpu_stall = 1'b0;
        irq_take  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                gate_o = ALL_ON;
            end
            ST_SLEEP: begin
                gate_o    = sleep_gate;
                cpu_stall = 1'b1;
            end
            ST_START: begin
                gate_o     = sleep_gate;
                gate_o.osc = 1'b1;
                cpu_stall  = 1'b1;
            end
            ST_HALT: begin
                gate_o    = ALL_ON;
                cpu_stall = 1'b1;
            end
            ST_SERVE: begin
                gate_o   = ALL_ON;
                irq_take = 1'b1;
            end
            default: begin
                gate_o = ALL_ON;
            end
        endcase
    end

    assign clk_cpu_en   = gate_o.cpu;
    assign clk_io_en    = gate_o.io;
    assign clk_adc_en   = gate_o.adc;
    assign clk_async_en = gate_o.asyn;
    assign osc_en       = gate_o.osc;
    assign core_rst     = core_rst_q;

endmodule

// File: rtl/sleep_sequencer_chk.sv
module sleep_sequencer_chk
    import sleep_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   rst_req,
    input logic   sleep_en,
    input logic   sleep_strobe,
    input logic   cpu_stall,
    input logic   irq_take,
    input logic   core_rst,
    input logic   clk_cpu_en,
    input logic   clk_io_en,
    input logic   clk_adc_en,
    input logic   clk_async_en,
    input logic   osc_en,
    input state_e st,
    input mode_e  mode
);

    logic [4:0] en_vec;
    assign en_vec = {clk_cpu_en, clk_io_en, clk_adc_en, clk_async_en, osc_en};

    AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && sleep_strobe && sleep_en && !rst_req) |=> cpu_stall); // R1

    AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && sleep_strobe && !sleep_en && !rst_req) |=> !cpu_stall); // R1

    AST_PDOWN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && mode == MD_PDOWN) |-> (en_vec == 5'b00000)); // R3

    AST_START_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START) |-> osc_en); // R6

    AST_HALT_BEFORE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($past(cpu_stall, 1) && $past(cpu_stall, 4))); // R7

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> (!irq_take && !cpu_stall)); // R7

    AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (!cpu_stall && !irq_take && core_rst)); // R8

    AST_CORE_RST_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> $past(rst_req)); // R9

    AST_RUN_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_stall |-> (en_vec == 5'b11111)); // R10

endmodule

bind sleep_sequencer sleep_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_req      (rst_req),
    .sleep_en     (sleep_en),
    .sleep_strobe (sleep_strobe),
    .cpu_stall    (cpu_stall),
    .irq_take     (irq_take),
    .core_rst     (core_rst),
    .clk_cpu_en   (clk_cpu_en),
    .clk_io_en    (clk_io_en),
    .clk_adc_en   (clk_adc_en),
    .clk_async_en (clk_async_en),
    .osc_en       (osc_en),
    .st           (st_q),
    .mode         (mode_w)
);

// File: tb/sim_sleep_sequencer.sv
`timescale 1ns/1ps
module sim_sleep_sequencer;

    localparam int LONG_T  = 20;
    localparam int SHORT_T = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_req = 1'b0;
    logic       sleep_en = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic       sleep_strobe = 1'b0;
    logic       int0_req = 1'b0;
    logic       int0_level = 1'b0;
    logic       pin_irq = 1'b0;
    logic       wdt_irq = 1'b0;
    logic       adc_irq = 1'b0;
    logic       io_irq = 1'b0;
    logic       tmr_irq = 1'b0;
    logic       cpu_stall, irq_take, core_rst;
    logic       clk_cpu_en, clk_io_en, clk_adc_en, clk_async_en, osc_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sleep_sequencer #(.LONG_CYC(LONG_T), .SHORT_CYC(SHORT_T)) u0 (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .sleep_en(sleep_en),
        .mode_sel(mode_sel), .sleep_strobe(sleep_strobe),
        .int0_req(int0_req), .int0_level(int0_level), .pin_irq(pin_irq),
        .wdt_irq(wdt_irq), .adc_irq(adc_irq), .io_irq(io_irq), .tmr_irq(tmr_irq),
        .cpu_stall(cpu_stall), .irq_take(irq_take), .core_rst(core_rst),
        .clk_cpu_en(clk_cpu_en), .clk_io_en(clk_io_en), .clk_adc_en(clk_adc_en),
        .clk_async_en(clk_async_en), .osc_en(osc_en)
    );

    function automatic logic [4:0] en_now();
        return {clk_cpu_en, clk_io_en, clk_adc_en, clk_async_en, osc_en};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // 0 idle, 1 adc noise reduction, 2 power-down, 3 power-save, 4 standby
    function automatic int mode_of(input int code);
        case (code)
            1: return 1;
            2: return 2;
            3: return 3;
            6: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [4:0] gate_of(input int m);
        case (m)
            1: return 5'b00111;
            2: return 5'b00000;
            3: return 5'b00010;
            4: return 5'b00001;
            default: return 5'b01111;
        endcase
    endfunction

    function automatic int start_of(input int m);
        if (m == 2 || m == 3) return LONG_T;
        if (m == 4) return SHORT_T;
        return 0;
    endfunction

    // sources: 0 int0 edge, 1 int0 level, 2 pin, 3 wdt, 4 adc, 5 io, 6 tmr
    function automatic bit wakes(input int m, input int src);
        bit deep = (m >= 2);
        case (src)
            0: return !deep;
            1: return 1'b1;
            2: return 1'b1;
            3: return 1'b1;
            4: return (m <= 1);
            5: return (m == 0);
            6: return (m <= 1) || (m == 3);
            default: return 1'b0;
        endcase
    endfunction

    task automatic set_src(input int src, input bit v);
        int0_level = (src == 1) ? v : 1'b0;
        int0_req   = (src == 0 || src == 1) ? v : 1'b0;
        pin_irq    = (src == 2) ? v : 1'b0;
        wdt_irq    = (src == 3) ? v : 1'b0;
        adc_irq    = (src == 4) ? v : 1'b0;
        io_irq     = (src == 5) ? v : 1'b0;
        tmr_irq    = (src == 6) ? v : 1'b0;
    endtask

    task automatic enter_sleep(input int code);
        sleep_en = 1'b1;
        mode_sel = 3'(code);
        sleep_strobe = 1'b1;
        step();
        sleep_strobe = 1'b0;
        sleep_en = 1'b0;
        mode_sel = 3'b000;
    endtask

    // called at the first sample after the waking edge
    task automatic measure_wake(input int m);
        int n = 0;
        bit osc_bad = 1'b0;
        bit rst_bad = 1'b0;
        while (!irq_take && n < LONG_T + 40) begin
            if (!osc_en) osc_bad = 1'b1;
            if (core_rst) rst_bad = 1'b1;
            if (!cpu_stall) rst_bad = 1'b1;
            n++;
            step();
        end
        check(n == start_of(m) + 4, "R6/R7", "stall length after wake", n, start_of(m) + 4);
        check(!osc_bad, "R6", "osc_en during start-up", osc_bad, 0);
        check(!rst_bad, "R9", "core_rst or early release during wake", rst_bad, 0);
        check(irq_take && !cpu_stall, "R7", "irq_take pulse", irq_take, 1);
        step();
        check(!irq_take, "R7", "irq_take single cycle", irq_take, 0);
        check(!cpu_stall && en_now() == 5'b11111, "R10", "run after wake", en_now(), 31);
    endtask

    task automatic run_case(input int code, input int src);
        int m = mode_of(code);
        enter_sleep(code);
        check(cpu_stall == 1'b1, "R1", "stall after armed strobe", cpu_stall, 1);
        check(en_now() == gate_of(m), "R2/R3", $sformatf("gates code %0d", code),
              en_now(), gate_of(m));
        set_src(src, 1'b1);
        step();
        set_src(src, 1'b0);
        if (wakes(m, src)) begin
            measure_wake(m);
        end else begin
            step();
            check(cpu_stall && !irq_take && en_now() == gate_of(m),
                  (src == 0) ? "R5" : "R4",
                  $sformatf("no wake code %0d src %0d", code, src), en_now(), gate_of(m));
            pin_irq = 1'b1;
            step();
            pin_irq = 1'b0;
            measure_wake(m);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        check(!cpu_stall && !irq_take && !core_rst, "R10", "reset state stall", cpu_stall, 0);
        check(en_now() == 5'b11111, "R10", "reset state clocks", en_now(), 31);

        // disarmed strobe
        sleep_strobe = 1'b1;
        mode_sel = 3'b010;
        step();
        sleep_strobe = 1'b0;
        check(!cpu_stall, "R1", "strobe ignored without sleep_en", cpu_stall, 0);
        step();
        check(!cpu_stall && en_now() == 5'b11111, "R1", "still running", en_now(), 31);

        // sweep of every mode code against every source
        for (int code = 0; code < 8; code++) begin
            for (int src = 0; src < 7; src++) begin
                run_case(code, src);
            end
        end

        // reset request while asleep in power-down
        enter_sleep(2);
        check(cpu_stall, "R1", "asleep before reset", cpu_stall, 1);
        rst_req = 1'b1;
        step();
        rst_req = 1'b0;
        check(!cpu_stall && !irq_take && core_rst, "R8", "reset exits sleep", core_rst, 1);
        check(en_now() == 5'b11111, "R8", "clocks on after reset", en_now(), 31);
        step();
        check(!core_rst, "R9", "core_rst one cycle", core_rst, 0);

        // reset request during standby start-up
        enter_sleep(6);
        wdt_irq = 1'b1;
        step();
        wdt_irq = 1'b0;
        step();
        check(cpu_stall && osc_en && !clk_cpu_en, "R6", "in standby start-up", en_now(), 1);
        rst_req = 1'b1;
        step();
        rst_req = 1'b0;
        check(!cpu_stall && core_rst && !irq_take, "R8", "reset during start-up", core_rst, 1);
        step();
        check(!irq_take && !cpu_stall, "R8", "no service after reset", irq_take, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule